// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a system controller read and write a bank of 8-bit configuration registers over a two-wire, SMBus-compatible serial bus. A fast system clock oversamples the clock line and the data line. The block answers a single fixed device address. It drives the data line only through an open-drain pull-low enable, and it never stretches the clock.

Each access opens with the device address in write direction, followed by a command byte. When bit 7 of the command is set, the access is byte-oriented and bits 6:0 give the register offset. When bit 7 is clear, the access is block-oriented and always starts at register 0. In that case a block write carries a byte count ahead of its data. A block read answers first with the value of a programmable count register and then sends that many registers.

Register 7 is a fixed identification byte. Register 12 sets the length of block reads. Offsets that are not implemented are still acknowledged: writes to them are lost and reads from them return zero. The whole register image is available in parallel for use by the rest of the chip.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, register 7 reads 48h, register 12 reads 0Fh, every other register reads 00h, and the data-line drive is released.
- R2: The slave acknowledges only the 7-bit address 69h, which is D2h with the write bit (bit 0 = 0) and D3h with the read bit (bit 0 = 1). For any other address it sends no acknowledge and never drives the data line until the next START.
- R3: A command byte with bit 7 = 1 followed by a data byte writes that byte to the register at the offset in command bits 6:0, and the slave acknowledges every byte.
- R4: A byte read is address (write), a command with bit 7 = 1, a repeated START, then address (read). It returns the register at the commanded offset, most significant bit first.
- R5: A block write is a command of 00h, then a byte count (not stored), then data bytes. These land in registers 0, 1, 2 and upward in order. A STOP after any complete byte leaves the higher registers unchanged.
- R6: A block read is a command of 00h, a repeated START, then address (read). The slave first returns the value of register 12 (N), then registers 0 to N-1. After those N bytes it leaves the data line released, so the master reads FFh.
- R7: Register 7 is read-only. Writes to it, by byte or block access, are acknowledged and discarded.
- R8: Offsets at or above the number of implemented registers (16) are acknowledged. Writes to them change no register, and reads from them return 00h.
- R9: The slave changes its data-line drive only while the clock line is low. It releases the line during the master's acknowledge slot and on STOP. A master NACK ends a read, and after it the slave drives nothing.
- R10: Raising register 12 lengthens block reads. With a count of 16, a block read returns registers 0 to 15.
- R11: In byte mode, data bytes that follow one another auto-increment the offset. This holds for writes and for reads that the master acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| cfg_regs | output | 128 | All registers, register i in bits 8i+7:8i |

## Verification
The assertions check on every cycle that the drive enable only turns on while the clock line is low, that STOP releases the line, that an unaddressed slave stays silent, that accepted writes reach the addressed register, and that writes to unimplemented offsets change nothing. Other behaviour shows only in the bench's transactions. This covers which address gets an acknowledge, the byte order of block reads and where they end, the auto-increment of offsets, the count byte being skipped, early STOPs, and how a change to register 12 alters the length of a later block read. The bench sweeps all 128 addresses, every offset up to 19, and several block lengths.

// File: rtl/smb_slv_pkg.sv
// Package: shared types for the two-wire register slave.
// Assumes: one byte per register; the protocol engine walks through the states below.
package smb_slv_pkg;
    localparam int BYTE_W = 8;

    // Protocol engine state
    typedef enum logic [1:0] {
        ST_IDLE,   // not addressed, bus ignored until START
        ST_ADDR,   // shifting in the address byte
        ST_WR,     // receiving command / count / data bytes
        ST_RD      // transmitting bytes to the master
    } smb_state_t;

    // Meaning of the next byte received in write direction
    typedef enum logic [1:0] {
        PH_CMD,
        PH_CNT,
        PH_DATA
    } wr_phase_t;
endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings SCL and SDA into the system clock domain through a synchroniser chain
// and flags clock edges and START/STOP conditions as one-cycle pulses.
// Assumes: STAGES >= 2; the system clock runs several times faster than SCL,
// so each bus event lasts several system cycles.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains plus one history flop per line; an idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smb_reg_bank.sv
// Module: smb_reg_bank
// Holds the configuration registers with their reset defaults. One register is
// a read-only identification constant. A write to an offset at or above
// NUM_REGS is dropped, and a read from such an offset returns zero.
// Assumes: NUM_REGS <= 127 so that every offset fits in a 7-bit pointer.
module smb_reg_bank #(
    parameter int          NUM_REGS = 16,
    parameter int          ID_IDX   = 7,
    parameter logic [7:0]  ID_VAL   = 8'h48,
    parameter int          CNT_IDX  = 12,
    parameter logic [7:0]  CNT_RST  = 8'h0F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [6:0]              waddr,
    input  logic [7:0]              wdata,
    input  logic [6:0]              raddr,
    output logic [7:0]              rdata,
    output logic [7:0]              cnt_q,
    output logic [NUM_REGS*8-1:0]   cfg_flat
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] regs [NUM_REGS];

    function automatic logic [7:0] reset_value(input int idx);
        return (idx == CNT_IDX) ? CNT_RST : 8'h00;
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == ID_IDX) begin : g_ro
            assign regs[i] = ID_VAL;
        end else begin : g_rw
            logic [7:0] q;
            // Writable register: load default on reset, take data on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= reset_value(i);
                else if (we && waddr == 7'(i))
                    q <= wdata;
            end
            assign regs[i] = q;
        end
        assign cfg_flat[i*8 +: 8] = regs[i];
    end

    // Read port: an offset beyond the array reads as zero
    always_comb begin
        if (raddr < 7'(NUM_REGS))
            rdata = regs[raddr[IDX_W-1:0]];
        else
            rdata = 8'h00;
        cnt_q = regs[CNT_IDX];
    end

    AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= 7'(NUM_REGS)) |=> $stable(cfg_flat)) else $error("write outside array changed state"); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr < 7'(NUM_REGS) && waddr != 7'(ID_IDX)) |=>
        regs[$past(waddr[IDX_W-1:0])] == $past(wdata)) else $error("accepted write did not land"); // R3
endmodule

// File: rtl/smb_proto_fsm.sv
// Module: smb_proto_fsm
// Bit-level and byte-level engine for the two-wire protocol. It shifts bits in
// on SCL rises and changes its own drive only after SCL falls. It decodes the
// address, command and count bytes and keeps the register pointer, which
// auto-increments.
// Assumes: event pulses come from smb_line_sync; slot 8 of every byte is the
// acknowledge slot.
module smb_proto_fsm
    import smb_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    input  logic [7:0] cnt_val,
    output logic [6:0] ptr,
    output logic       we,
    output logic [6:0] waddr,
    output logic [7:0] wdata,
    output logic       sda_oe
);
    smb_state_t state;
    wr_phase_t  wr_ph;
    logic [3:0] slot;
    logic       skip_fall;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic       rw;
    logic       block_mode;
    logic       m_nack;
    logic [7:0] rem;

    logic [7:0] first_tx;
    logic [7:0] next_tx;
    logic [2:0] bit_sel;

    // Byte to send next: count or register for the first byte, then data or filler
    always_comb begin
        first_tx = block_mode ? cnt_val : rd_data;
        next_tx  = (block_mode && rem == 8'd0) ? 8'hFF : rd_data;
        bit_sel  = 3'd6 - slot[2:0];
    end

    // Protocol sequencing: conditions first, then sampling on rise, then action on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wr_ph      <= PH_CMD;
            slot       <= 4'd0;
            skip_fall  <= 1'b0;
            shreg      <= 8'h00;
            txreg      <= 8'hFF;
            rw         <= 1'b0;
            block_mode <= 1'b0;
            m_nack     <= 1'b1;
            rem        <= 8'd0;
            ptr        <= 7'd0;
            we         <= 1'b0;
            waddr      <= 7'd0;
            wdata      <= 8'h00;
            sda_oe     <= 1'b0;
        end else begin
            we <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                slot      <= 4'd0;
                skip_fall <= 1'b1;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (slot < 4'd8)
                        shreg <= {shreg[6:0], sda_s};
                    else
                        m_nack <= sda_s;
                end
                if (scl_fall) begin
                    if (skip_fall) begin
                        skip_fall <= 1'b0;
                    end else if (slot != 4'd8) begin
                        slot <= slot + 4'd1;
                        if (state == ST_RD) begin
                            // Transmit: next data bit, or let go for the master's ACK
                            sda_oe <= (slot == 4'd7) ? 1'b0 : ~txreg[bit_sel];
                        end else if (slot == 4'd7) begin
                            // A whole byte has been received
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                case (wr_ph)
                                    PH_CMD: begin
                                        block_mode <= ~shreg[7];
                                        ptr        <= shreg[7] ? shreg[6:0] : 7'd0;
                                        wr_ph      <= shreg[7] ? PH_DATA : PH_CNT;
                                    end
                                    PH_CNT: wr_ph <= PH_DATA;
                                    default: begin
                                        we    <= 1'b1;
                                        waddr <= ptr;
                                        wdata <= shreg;
                                        ptr   <= ptr + 7'd1;
                                    end
                                endcase
                            end
                        end
                    end else begin
                        // End of the acknowledge slot
                        slot <= 4'd0;
                        if (state == ST_ADDR) begin
                            if (rw) begin
                                state  <= ST_RD;
                                txreg  <= first_tx;
                                sda_oe <= ~first_tx[7];
                                if (block_mode) rem <= cnt_val;
                                else            ptr <= ptr + 7'd1;
                            end else begin
                                state  <= ST_WR;
                                wr_ph  <= PH_CMD;
                                sda_oe <= 1'b0;
                            end
                        end else if (state == ST_RD) begin
                            if (m_nack) begin
                                state  <= ST_IDLE;
                                sda_oe <= 1'b0;
                            end else begin
                                txreg  <= next_tx;
                                sda_oe <= ~next_tx[7];
                                if (!(block_mode && rem == 8'd0)) begin
                                    ptr <= ptr + 7'd1;
                                    if (block_mode) rem <= rem - 8'd1;
                                end
                            end
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s) else $error("drive began with SCL high"); // R9
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe) else $error("drive held after STOP"); // R9
    AST_UNADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state == ST_IDLE)) |-> !sda_oe) else $error("idle slave drives SDA"); // R2
    AST_NO_WRITE_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |-> !we) else $error("register write during read"); // R4
endmodule

// File: rtl/smb_reg_slave.sv
// Module: smb_reg_slave (top)
// Two-wire register slave: line synchroniser, protocol engine and register bank.
// Assumes: the pad pulls SDA low while sda_oe is 1 and releases it otherwise;
// the system clock runs at least 8 times faster than SCL.
module smb_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 16,
    parameter int         ID_IDX      = 7,
    parameter logic [7:0] ID_VAL      = 8'h48,
    parameter int         CNT_IDX     = 12,
    parameter logic [7:0] CNT_RST     = 8'h0F,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] ptr;
    logic       we;
    logic [6:0] waddr;
    logic [7:0] wdata;
    logic [7:0] rd_data;
    logic [7:0] cnt_q;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .cnt_val(cnt_q), .ptr(ptr),
        .we(we), .waddr(waddr), .wdata(wdata), .sda_oe(sda_oe)
    );

    smb_reg_bank #(
        .NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
        .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ptr), .rdata(rd_data), .cnt_q(cnt_q), .cfg_flat(cfg_regs)
    );
endmodule

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;     // system cycles per quarter of an SCL period
    localparam int NREG       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    wire  sda_line = ~(m_low | sda_oe);

    int checks = 0;
    int fails = 0;
    int drive_viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_regs(cfg)
    );

    // Bus monitor: the drive must never switch on while SCL is high (R9)
    always @(negedge clk) begin
        if (rst_n && sda_oe && !prev_oe && scl) drive_viol++;
        prev_oe <= sda_oe;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: act=hung exp=done");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cfg_byte(input int i);
        return cfg[i*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_read(input int off);
        return (off < NREG) ? model[off] : 8'h00;
    endfunction

    task automatic bus_start();
        if (!scl) begin
            wcyc(Q); m_low = 1'b0; wcyc(Q); scl = 1'b1; wcyc(Q);
        end
        m_low = 1'b1; wcyc(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wcyc(Q); m_low = 1'b1; wcyc(Q); scl = 1'b1; wcyc(Q); m_low = 1'b0; wcyc(4*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wcyc(Q); m_low = ~b[i]; wcyc(Q); scl = 1'b1; wcyc(2*Q); scl = 1'b0;
        end
        wcyc(Q); m_low = 1'b0; wcyc(Q); scl = 1'b1; wcyc(Q);
        ack = ~sda_line;
        wcyc(Q); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wcyc(2*Q); scl = 1'b1; wcyc(Q); b[i] = sda_line; wcyc(Q); scl = 1'b0;
        end
        wcyc(Q); m_low = ~nack; wcyc(Q); scl = 1'b1; wcyc(2*Q); scl = 1'b0;
    endtask

    task automatic byte_write(input int off, input logic [7:0] val, output bit all_ack);
        bit a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h80 | 8'(off), a1);
        send_byte(val, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
        if (off < NREG && off != 7) model[off] = val;
    endtask

    task automatic byte_read(input int off, output logic [7:0] val);
        bit a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h80 | 8'(off), a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, val);
        bus_stop();
    endtask

    logic [7:0] rv, rv2, cnt;
    bit ok, a;

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = (i == 7) ? 8'h48 : (i == 12) ? 8'h0F : 8'h00;
        wcyc(5); rst_n = 1'b1; wcyc(5);

        // R1: reset image and released drive
        for (int i = 0; i < NREG; i++) chk(cfg_byte(i) == model[i], "R1 reset value", cfg_byte(i), model[i]);
        chk(sda_oe == 1'b0, "R1 drive released", sda_oe, 0);

        // R2: exhaustive address sweep, write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            bus_stop();
            chk(a == (ad == 'h69), "R2 address ack", a, (ad == 'h69));
        end

        // R3/R7/R8: byte write sweep over implemented and missing offsets
        for (int off = 0; off < 20; off++) begin
            byte_write(off, 8'((off * 29 + 3) & 8'hFF), ok);
            chk(ok, "R3 byte write acks", ok, 1);
        end
        for (int i = 0; i < NREG; i++) chk(cfg_byte(i) == model[i], "R3 R7 R8 register image", cfg_byte(i), model[i]);
        chk(cfg_byte(7) == 8'h48, "R7 id unchanged", cfg_byte(7), 8'h48);

        // R4/R8: byte read sweep
        for (int off = 0; off < 20; off++) begin
            byte_read(off, rv);
            chk(rv == exp_read(off), "R4 R8 byte read", rv, exp_read(off));
        end

        // R11: auto-increment in byte mode, write then acknowledged read
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h83, a); send_byte(8'hA5, a); send_byte(8'h5A, a);
        bus_stop();
        model[3] = 8'hA5; model[4] = 8'h5A;
        chk(cfg_byte(3) == 8'hA5, "R11 write offset", cfg_byte(3), 8'hA5);
        chk(cfg_byte(4) == 8'h5A, "R11 write offset+1", cfg_byte(4), 8'h5A);
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h83, a);
        bus_start(); send_byte(8'hD3, a);
        recv_byte(1'b0, rv); recv_byte(1'b1, rv2);
        bus_stop();
        chk(rv == 8'hA5, "R11 read offset", rv, 8'hA5);
        chk(rv2 == 8'h5A, "R11 read offset+1", rv2, 8'h5A);
        chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);

        // R5: block write with early STOP after three data bytes
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd5, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hC0 + 8'(i), a);
            model[i] = 8'hC0 + 8'(i);
        end
        bus_stop();
        for (int i = 0; i < 6; i++) chk(cfg_byte(i) == model[i], "R5 block write early stop", cfg_byte(i), model[i]);

        // R5/R7: block write across the identification byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd10, a);
        for (int i = 0; i < 10; i++) begin
            send_byte(8'h10 + 8'(i * 3), ok);
            chk(ok, "R5 block data ack", ok, 1);
            if (i != 7) model[i] = 8'h10 + 8'(i * 3);
        end
        bus_stop();
        for (int i = 0; i < NREG; i++) chk(cfg_byte(i) == model[i], "R5 R7 block write image", cfg_byte(i), model[i]);

        // R6/R10: block reads with counts 15, 16 and 3
        for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 15 : (k == 1) ? 16 : 3;
            byte_write(12, 8'(n), ok);
            bus_start();
            send_byte(8'hD2, a); send_byte(8'h00, a);
            bus_start(); send_byte(8'hD3, a);
            recv_byte(1'b0, cnt);
            chk(cnt == 8'(n), "R6 R10 count byte", cnt, n);
            for (int i = 0; i <= n; i++) begin
                recv_byte(i == n, rv);
                if (i < n) chk(rv == model[i], "R6 R10 block data", rv, model[i]);
                else       chk(rv == 8'hFF, "R6 past count", rv, 8'hFF);
            end
            bus_stop();
        end

        chk(drive_viol == 0, "R9 drive only with SCL low", drive_viol, 0);
        finish_run();
    end
endmodule